// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table with Pending Replay

This block holds a small table of interrupt vectors, each with a message address, a message data word and a per-entry mask bit. It also holds a read-only pending-bit array. Software reaches the table, the pending array and the source-to-vector select registers through one dword register port, addressed relative to the device's memory window. Interrupt requests come from one configuration-change source and from a number of per-queue completion sources. Each source is steered to a vector by its own select register.

A request on a deliverable vector produces one message write on a valid/ready output bus. A vector is deliverable when the function-level enable is set, the function mask is clear and the entry mask is clear. A request on a vector that is not deliverable is recorded as pending and is shown in the pending array. When the vector later becomes deliverable, the block sends the message and clears the pending bit without help from software. Only one message is in flight at a time. Several vectors may wait together, and the lowest-numbered one goes first.

Back-pressure rules: `msg_valid` stays high with `msg_addr` and `msg_data` held steady until a cycle in which `msg_ready` is high. The transfer completes at that clock edge. The block may present the next message in the very next cycle. A request is never lost while the bus is stalled. Requests to the same vector that arrive while a message for that vector is still waiting merge into one message.

Top module: `msix_vec_unit`

## Requirements
- R1: Entry n occupies byte offsets 16n to 16n+15. The dword at 16n+0 is address low, 16n+4 is address high, 16n+8 is data and 16n+12 is control. Control bit 0 is the entry mask, and the other control bits read 0. After reset every address and data dword is 0 and every mask is 1.
- R2: Inside the table region (offsets 0x000 to 0x3FF), a write to an entry at index NV or above is ignored, and a read of such an entry returns 0.
- R3: The dword at 0x400 is the pending array: bit n is 1 while vector n has a waiting request and is not deliverable. Writes to it have no effect.
- R4: A vector n is deliverable only when `ctl_enable` is 1, `ctl_fmask` is 0 and the mask bit of entry n is 0.
- R5: A request on a non-deliverable vector sets its pending bit and sends nothing. A request on a deliverable vector sends its message with address {high, low} and the entry's data, and its pending bit stays 0. The request is sampled at a clock edge, and the message appears after the next edge if the bus is free.
- R6: When a vector with a pending request becomes deliverable, its message is sent and its pending bit clears. This happens whether the change comes from an entry-mask clear, from enable being set or from the function mask being cleared.
- R7: The select registers hold 16-bit values: 0x800 is the configuration-change select, and 0x804+4q is the select for queue q. All of them reset to 0xFFFF (no vector). A written value below NV is stored as is. Any other written value is stored as 0xFFFF. A read returns the stored value zero-extended.
- R8: A configuration event requests only the vector in the configuration select, and an event on queue q requests only the vector in queue q's select. An event whose select is 0xFFFF is dropped.
- R9: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid`, `msg_addr` and `msg_data` stay unchanged. At most one message is in flight.
- R10: When several vectors are both pending and deliverable, their messages leave in ascending vector order.
- R11: A request that arrives in the same cycle as its vector's message launch causes a second message. Repeated requests to a vector before its message launches merge into one message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | AW | Byte offset of the accessed dword |
| reg_wr | input | 1 | Write strobe for the dword at reg_addr |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ctl_enable | input | 1 | Function-level message enable |
| ctl_fmask | input | 1 | Function-level mask |
| cfg_evt | input | 1 | Configuration-change request, one per high cycle |
| q_evt | input | NQ | Per-queue completion requests |
| msg_valid | output | 1 | Message write is presented |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Two functions can meet in one cycle: clearing a vector's pending state as its message launches, and setting it again for a fresh request on that same vector. The bench holds a queue event high for two consecutive edges. The first edge records the request, and the second edge launches the message while the new request arrives. The scoreboard must then see exactly two messages for that vector. A second case checks that a stalled launch and an unmask arrive together without loss: several vectors are released at once under back-pressure, and the bench judges the order and the stability of the held message.

// File: rtl/msix_pkg.sv
package msix_pkg;
  localparam logic [15:0] NO_VEC = 16'hFFFF;

  typedef enum logic [1:0] {
    RGN_TBL  = 2'd0,
    RGN_PBA  = 2'd1,
    RGN_SEL  = 2'd2,
    RGN_NONE = 2'd3
  } rgn_e;

  typedef struct packed {
    logic [31:0] lo;
    logic [31:0] hi;
    logic [31:0] data;
    logic        mask;
  } entry_t;
endpackage

// File: rtl/msix_table.sv
module msix_table
  import msix_pkg::*;
#(
  parameter int NV = 4,
  parameter int IW = 6,
  parameter int VW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [IW-1:0] idx,
  input  logic [1:0]    dw,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic [NV-1:0] mask,
  input  logic [VW-1:0] lk_idx,
  output logic [63:0]   lk_addr,
  output logic [31:0]   lk_data
);
  entry_t tbl [NV];

  for (genvar i = 0; i < NV; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tbl[i] <= '{lo: '0, hi: '0, data: '0, mask: 1'b1};
      end else if (wr && idx == IW'(i)) begin
        case (dw)
          2'd0: tbl[i].lo   <= wdata;
          2'd1: tbl[i].hi   <= wdata;
          2'd2: tbl[i].data <= wdata;
          default: tbl[i].mask <= wdata[0];
        endcase
      end
    end
    assign mask[i] = tbl[i].mask;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NV; i++) begin
      if (idx == IW'(i)) begin
        case (dw)
          2'd0: rdata = tbl[i].lo;
          2'd1: rdata = tbl[i].hi;
          2'd2: rdata = tbl[i].data;
          default: rdata = {31'd0, tbl[i].mask};
        endcase
      end
    end
  end

  always_comb begin
    lk_addr = '0;
    lk_data = '0;
    for (int i = 0; i < NV; i++) begin
      if (lk_idx == VW'(i)) begin
        lk_addr = {tbl[i].hi, tbl[i].lo};
        lk_data = tbl[i].data;
      end
    end
  end
endmodule

// File: rtl/msix_sel.sv
module msix_sel
  import msix_pkg::*;
#(
  parameter int NV = 4,
  parameter int NQ = 2,
  parameter int SW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [SW-1:0]         sidx,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  input  logic                  cfg_evt,
  input  logic [NQ-1:0]         q_evt,
  output logic [NV-1:0]         req,
  output logic [16*(NQ+1)-1:0]  sel_flat
);
  localparam int NS = NQ + 1;

  logic [15:0] sel [NS];
  logic [NS-1:0] fire;
  logic [15:0] wval;

  assign fire = {q_evt, cfg_evt};
  assign wval = (wdata[15:0] < 16'(NV)) ? wdata[15:0] : NO_VEC;

  for (genvar s = 0; s < NS; s++) begin : g_sel
    always_ff @(posedge clk) begin
      if (!rst_n)                         sel[s] <= NO_VEC;
      else if (wr && sidx == SW'(s))      sel[s] <= wval;
    end
    assign sel_flat[16*s +: 16] = sel[s];
  end

  always_comb begin
    rdata = '0;
    for (int s = 0; s < NS; s++)
      if (sidx == SW'(s)) rdata = {16'd0, sel[s]};
  end

  always_comb begin
    req = '0;
    for (int s = 0; s < NS; s++)
      for (int v = 0; v < NV; v++)
        if (fire[s] && sel[s] == 16'(v)) req[v] = 1'b1;
  end
endmodule

// File: rtl/msix_arb.sv
module msix_arb #(
  parameter int NV = 4,
  parameter int VW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NV-1:0] req,
  input  logic [NV-1:0] deliv,
  output logic [NV-1:0] pend,
  output logic [NV-1:0] gnt,
  output logic [VW-1:0] gidx,
  input  logic [63:0]   lk_addr,
  input  logic [31:0]   lk_data,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [63:0]   msg_addr,
  output logic [31:0]   msg_data
);
  logic [NV-1:0] cand;
  logic          launch;

  assign cand = pend & deliv;

  always_comb begin
    gnt  = '0;
    gidx = '0;
    for (int v = NV - 1; v >= 0; v--) begin
      if (cand[v]) begin
        gnt     = '0;
        gnt[v]  = 1'b1;
        gidx    = VW'(v);
      end
    end
  end

  assign launch = (!msg_valid || msg_ready) && (|cand);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      pend      <= (pend & ~(launch ? gnt : '0)) | req;
      msg_valid <= launch | (msg_valid & ~msg_ready);
      if (launch) begin
        msg_addr <= lk_addr;
        msg_data <= lk_data;
      end
    end
  end
endmodule

// File: rtl/msix_vec_unit.sv
module msix_vec_unit
  import msix_pkg::*;
#(
  parameter int NV = 4,
  parameter int NQ = 2,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          ctl_enable,
  input  logic          ctl_fmask,
  input  logic          cfg_evt,
  input  logic [NQ-1:0] q_evt,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [63:0]   msg_addr,
  output logic [31:0]   msg_data
);
  localparam int VW = (NV > 1) ? $clog2(NV) : 1;
  localparam int IW = AW - 6;
  localparam int SW = AW - 4;

  rgn_e        rgn;
  logic [31:0] tbl_rd, sel_rd;
  logic [NV-1:0] mask, deliv, req, pend, gnt, pba;
  logic [VW-1:0] gidx;
  logic [63:0] lk_addr;
  logic [31:0] lk_data;
  logic [16*(NQ+1)-1:0] sel_flat;

  assign rgn = rgn_e'(reg_addr[AW-1 -: 2]);

  assign deliv = {NV{ctl_enable & ~ctl_fmask}} & ~mask;
  assign pba   = pend & ~deliv;

  msix_table #(.NV(NV), .IW(IW), .VW(VW)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr(reg_wr && rgn == RGN_TBL),
    .idx(reg_addr[AW-3:4]), .dw(reg_addr[3:2]), .wdata(reg_wdata),
    .rdata(tbl_rd), .mask(mask),
    .lk_idx(gidx), .lk_addr(lk_addr), .lk_data(lk_data)
  );

  msix_sel #(.NV(NV), .NQ(NQ), .SW(SW)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .wr(reg_wr && rgn == RGN_SEL),
    .sidx(reg_addr[AW-3:2]), .wdata(reg_wdata), .rdata(sel_rd),
    .cfg_evt(cfg_evt), .q_evt(q_evt), .req(req), .sel_flat(sel_flat)
  );

  msix_arb #(.NV(NV), .VW(VW)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .req(req), .deliv(deliv), .pend(pend), .gnt(gnt), .gidx(gidx),
    .lk_addr(lk_addr), .lk_data(lk_data),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  always_comb begin
    case (rgn)
      RGN_TBL: reg_rdata = tbl_rd;
      RGN_PBA: reg_rdata = (reg_addr[AW-3:2] == '0) ? 32'(pba) : 32'd0;
      RGN_SEL: reg_rdata = sel_rd;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/msix_vec_chk.sv
module msix_vec_chk #(
  parameter int NV = 4,
  parameter int NQ = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ctl_enable,
  input logic                 ctl_fmask,
  input logic                 msg_valid,
  input logic                 msg_ready,
  input logic [63:0]          msg_addr,
  input logic [31:0]          msg_data,
  input logic [NV-1:0]        gnt,
  input logic [16*(NQ+1)-1:0] sel_flat
);
  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  // R4
  launch_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(ctl_enable && !ctl_fmask));

  // R10
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  for (genvar s = 0; s <= NQ; s++) begin : g_s
    // R7
    sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_flat[16*s +: 16] < 16'(NV)) || (sel_flat[16*s +: 16] == 16'hFFFF));
  end
endmodule

bind msix_vec_unit msix_vec_chk #(.NV(NV), .NQ(NQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_fmask(ctl_fmask),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
  .msg_data(msg_data), .gnt(gnt), .sel_flat(sel_flat)
);

// File: tb/msix_vec_unit_tb.sv
module msix_vec_unit_tb;
  localparam int NV = 4;
  localparam int NQ = 2;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic ctl_enable = 1'b0, ctl_fmask = 1'b0, cfg_evt = 1'b0;
  logic [NQ-1:0] q_evt = '0;
  logic msg_valid, msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int checks = 0, errors = 0;
  logic [95:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  msix_vec_unit #(.NV(NV), .NQ(NQ), .AW(AW)) u_dut (.*);

  task automatic chk(bit ok, string r, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [95:0] msg_of(int v);
    return {32'(v), 32'hFEE0_0000 + 32'(v * 16), 32'h4000 + 32'(v)};
  endfunction

  task automatic expect_msg(int v, string r);
    exp_q.push_back(msg_of(v));
    tag_q.push_back(r);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [31:0] e, string r);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    chk(reg_rdata == e, r, 96'(reg_rdata), 96'(e));
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic pulse(int src, int len);
    @(posedge clk); #1;
    if (src < 0) cfg_evt = 1'b1; else q_evt[src] = 1'b1;
    repeat (len) @(posedge clk);
    #1;
    cfg_evt = 1'b0; q_evt = '0;
  endtask

  task automatic drain(string r);
    for (int i = 0; i < 200 && exp_q.size() > 0; i++) @(posedge clk);
    idle(6);
    chk(exp_q.size() == 0, r, 96'(exp_q.size()), 96'd0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected message", {msg_addr, msg_data}, 96'd0);
      end else begin
        automatic logic [95:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk({msg_addr, msg_data} == e, t, {msg_addr, msg_data}, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 96'd0, 96'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3); #1; rst_n = 1'b1;
    // reset state
    @(negedge clk);
    chk(msg_valid == 1'b0, "R9 reset valid", 96'(msg_valid), 96'd0);
    rd(12'h800, 32'h0000_FFFF, "R7 reset cfg select");
    rd(12'h00C, 32'h1, "R1 reset mask");
    rd(12'h400, 32'h0, "R3 reset pending");
    // program table
    for (int v = 0; v < NV; v++) begin
      wr(12'(16 * v), 32'hFEE0_0000 + 32'(v * 16));
      wr(12'(16 * v + 4), 32'(v));
      wr(12'(16 * v + 8), 32'h4000 + 32'(v));
      wr(12'(16 * v + 12), 32'h10);
    end
    rd(12'h010, 32'hFEE0_0010, "R1 entry1 addr lo");
    rd(12'h014, 32'h1, "R1 entry1 addr hi");
    rd(12'h018, 32'h4001, "R1 entry1 data");
    rd(12'h01C, 32'h0, "R1 entry1 ctrl upper bits read 0");
    wr(12'h040, 32'hDEAD_BEEF);
    rd(12'h040, 32'h0, "R2 out-of-range entry");
    // selects
    wr(12'h800, 32'd4);
    rd(12'h800, 32'h0000_FFFF, "R7 clamp cfg select");
    wr(12'h800, 32'd0);
    rd(12'h800, 32'h0, "R7 cfg select stored");
    wr(12'h804, 32'hABCD);
    rd(12'h804, 32'h0000_FFFF, "R7 clamp queue select");
    wr(12'h804, 32'd1);
    wr(12'h808, 32'd2);
    rd(12'h804, 32'h1, "R7 queue0 select");
    // disabled: pending, no message
    pulse(-1, 1);
    idle(4);
    @(negedge clk);
    chk(msg_valid == 1'b0, "R5 no send while disabled", 96'(msg_valid), 96'd0);
    rd(12'h400, 32'h1, "R5 pending set");
    wr(12'h400, 32'hF);
    rd(12'h400, 32'h1, "R3 pending write ignored");
    // enable -> replay
    expect_msg(0, "R6 replay on enable");
    @(posedge clk); #1; ctl_enable = 1'b1;
    drain("R6 replay drained");
    rd(12'h400, 32'h0, "R6 pending cleared");
    // direct sends
    expect_msg(1, "R8 queue0 fires vector1");
    pulse(0, 1);
    drain("R5 direct send");
    rd(12'h400, 32'h0, "R5 pending stays clear");
    expect_msg(2, "R8 queue1 fires vector2");
    pulse(1, 1);
    drain("R8 queue1 drained");
    // entry mask then unmask
    wr(12'h02C, 32'h1);
    pulse(1, 1);
    idle(4);
    rd(12'h400, 32'h4, "R4 entry mask blocks");
    expect_msg(2, "R6 replay on unmask");
    wr(12'h02C, 32'h0);
    drain("R6 unmask drained");
    rd(12'h400, 32'h0, "R6 pending cleared after unmask");
    // arbitration with back-pressure
    @(posedge clk); #1; ctl_fmask = 1'b1;
    pulse(1, 1); pulse(0, 1); pulse(-1, 1);
    idle(2);
    rd(12'h400, 32'h7, "R4 function mask blocks");
    @(posedge clk); #1; msg_ready = 1'b0; ctl_fmask = 1'b0;
    expect_msg(0, "R10 order first");
    expect_msg(1, "R10 order second");
    expect_msg(2, "R10 order third");
    idle(3);
    @(negedge clk);
    chk(msg_valid && {msg_addr, msg_data} == msg_of(0), "R9 held message",
        {msg_addr, msg_data}, msg_of(0));
    idle(4);
    @(negedge clk);
    chk(msg_valid && {msg_addr, msg_data} == msg_of(0), "R9 still held",
        {msg_addr, msg_data}, msg_of(0));
    @(posedge clk); #1; msg_ready = 1'b1;
    drain("R10 all released");
    // dropped request
    wr(12'h808, 32'hFFFF);
    rd(12'h808, 32'h0000_FFFF, "R7 no-vector stored");
    pulse(1, 1);
    idle(5);
    @(negedge clk);
    chk(msg_valid == 1'b0, "R8 dropped request", 96'(msg_valid), 96'd0);
    rd(12'h400, 32'h0, "R8 no pending for dropped");
    // same-cycle launch and new request
    expect_msg(1, "R11 first of pair");
    expect_msg(1, "R11 second of pair");
    pulse(0, 2);
    drain("R11 pair drained");
    // merge
    @(posedge clk); #1; ctl_fmask = 1'b1;
    pulse(0, 1); pulse(0, 1); pulse(0, 1);
    rd(12'h400, 32'h2, "R11 merged pending");
    expect_msg(1, "R11 merged single message");
    @(posedge clk); #1; ctl_fmask = 1'b0;
    drain("R11 merge drained");
    idle(10);
    chk(exp_q.size() == 0, "R11 no extra message", 96'(exp_q.size()), 96'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule